// File: doc/BRIEF.md
# GPIO Interrupt Front End with Glitch Filter

This block sits between a group of GPIO input pins and a parent interrupt controller. Each line is gated by its own enable bit and reaches the parent on its own output wire. The block holds no pending or acknowledge state. Polarity and level-versus-edge sensing are left entirely to the parent.

A line can work in one of two ways. In pass-through mode it presents its level unchanged. In both-edge mode any accepted transition, rising or falling, becomes a short active-low pulse, which a parent that senses falling edges can use. Both-edge mode depends on a per-line digital glitch filter. The filter accepts a new level only after the input has held it for a programmed number of clock cycles, and all lines share that one period.

Four word registers set the per-line enable, mode and filter-enable bits and the shared filter period. These registers are written and read through a simple synchronous port.

Top module: `gpio_irq_front`

## Requirements
- R1: After reset the enable, mode and filter-enable registers read 0, the period register reads 0xFF, and every output in pass-through mode is 0.
- R2: Register offsets are fixed. 0x90 is the enable register, 0x94 the mode register (1 = both-edge), 0x98 the filter-enable register, and 0x9C the period register, held in bits [7:0]. In the first three registers, bit n belongs to line n and bits at or above NUM_LINES read 0. Writes to any other offset change nothing, and reads from any other offset return 0.
- R3: A disabled line drives its output to the idle level of its mode whatever its input does. That level is 0 in pass-through mode and 1 in both-edge mode.
- R4: With the filter off, an enabled pass-through line shows its input level at the output two clock edges after the input changes.
- R5: With the filter on and period P, a new input level reaches the output 1+P edges after it appears, provided it holds for P consecutive sampled cycles. A shorter excursion is discarded. A period of 0 behaves like 1.
- R6: In both-edge mode with the filter on, each accepted transition in either direction drives the output low for PULSE_CYCLES cycles (default 2), after which it returns high. A low pulse starts on the same edge at which the filtered level changes.
- R7: In both-edge mode with the filter off, no pulse is produced and the output stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| irq_in | input | NUM_LINES | Raw GPIO interrupt pins |
| irq_out | output | NUM_LINES | One interrupt wire per line to the parent controller |

## Verification
In pass-through mode the lines are driven with two distinct multi-bit patterns. This shows that each line follows its own input with the stated two-edge latency and that the lines do not affect one another. The filter is given a glitch one cycle shorter than the period and then a long level. This separates correct rejection from off-by-one acceptance, and the output is sampled exactly one cycle before and at the expected acceptance edge. Both-edge mode is tried with a rising and then a falling transition, and each pulse's width and start are sampled cycle by cycle. The same stimulus with the filter off, or with the line disabled, must leave the output at its idle level.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
    localparam logic [7:0] OFS_ENABLE = 8'h90;
    localparam logic [7:0] OFS_MODE   = 8'h94;
    localparam logic [7:0] OFS_FILTER = 8'h98;
    localparam logic [7:0] OFS_PERIOD = 8'h9C;
    localparam int         MAX_LINES  = 32;
    localparam int         DATA_W     = 32;
endpackage

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
    import gpio_irq_pkg::*;
#(
    parameter int NUM_LINES    = 8,
    parameter int PERIOD_W     = 8,
    parameter int PERIOD_RESET = 255
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [7:0]          addr,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   rdata,
    output logic [NUM_LINES-1:0] en_o,
    output logic [NUM_LINES-1:0] mode_o,
    output logic [NUM_LINES-1:0] flt_o,
    output logic [PERIOD_W-1:0] period_o
);
    typedef struct packed {
        logic [NUM_LINES-1:0] en;
        logic [NUM_LINES-1:0] mode;
        logic [NUM_LINES-1:0] flt;
        logic [PERIOD_W-1:0]  period;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            case (addr)
                OFS_ENABLE: cfg_d.en     = wdata[NUM_LINES-1:0];
                OFS_MODE:   cfg_d.mode   = wdata[NUM_LINES-1:0];
                OFS_FILTER: cfg_d.flt    = wdata[NUM_LINES-1:0];
                OFS_PERIOD: cfg_d.period = wdata[PERIOD_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.en     <= '0;
            cfg_q.mode   <= '0;
            cfg_q.flt    <= '0;
            cfg_q.period <= PERIOD_W'(PERIOD_RESET);
        end else begin
            cfg_q <= cfg_d;
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            OFS_ENABLE: rdata[NUM_LINES-1:0] = cfg_q.en;
            OFS_MODE:   rdata[NUM_LINES-1:0] = cfg_q.mode;
            OFS_FILTER: rdata[NUM_LINES-1:0] = cfg_q.flt;
            OFS_PERIOD: rdata[PERIOD_W-1:0]  = cfg_q.period;
            default:    rdata = '0;
        endcase
    end

    assign en_o     = cfg_q.en;
    assign mode_o   = cfg_q.mode;
    assign flt_o    = cfg_q.flt;
    assign period_o = cfg_q.period;

    // R2: a write to the enable offset lands in the register on the next edge
    p_enable_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en && addr == OFS_ENABLE) |-> en_o == $past(wdata[NUM_LINES-1:0]));

    // R2: a write to an unmapped offset leaves the enable bits alone
    p_unmapped_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en && addr != OFS_ENABLE) |-> $stable(en_o));
endmodule

// File: rtl/gpio_irq_lane.sv
module gpio_irq_lane #(
    parameter int PERIOD_W     = 8,
    parameter int PULSE_CYCLES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                raw_i,
    input  logic [PERIOD_W-1:0] period_i,
    input  logic                en_i,
    input  logic                mode_i,
    input  logic                flt_i,
    output logic                out_o
);
    localparam int CW = $clog2(PULSE_CYCLES + 1);

    typedef struct packed {
        logic                sync;
        logic                level;
        logic [PERIOD_W-1:0] cnt;
        logic [CW-1:0]       pulse;
    } lane_t;

    lane_t st_d, st_q;
    logic [PERIOD_W:0] cnt_next;
    logic              level_moved;

    always_comb begin
        st_d        = st_q;
        st_d.sync   = raw_i;
        cnt_next    = {1'b0, st_q.cnt} + (PERIOD_W + 1)'(1);
        if (!flt_i) begin
            st_d.level = st_q.sync;
            st_d.cnt   = '0;
        end else if (st_q.sync != st_q.level) begin
            if (cnt_next >= {1'b0, period_i}) begin
                st_d.level = st_q.sync;
                st_d.cnt   = '0;
            end else begin
                st_d.cnt   = cnt_next[PERIOD_W-1:0];
            end
        end else begin
            st_d.cnt = '0;
        end

        level_moved = (st_d.level != st_q.level);
        if (level_moved && mode_i && flt_i) begin
            st_d.pulse = CW'(PULSE_CYCLES);
        end else if (st_q.pulse != '0) begin
            st_d.pulse = st_q.pulse - CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        if (!en_i)       out_o = mode_i;
        else if (mode_i) out_o = (st_q.pulse == '0);
        else             out_o = st_q.level;
    end

    // R5: the filtered level only ever takes the value the input held
    p_accept_from_input_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.level != $past(st_q.level)) |-> (st_q.level == $past(st_q.sync)));

    // R6: a filtered change in both-edge mode starts a full-width pulse
    p_pulse_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode_i && flt_i) && st_q.level != $past(st_q.level))
            |-> (st_q.pulse == CW'(PULSE_CYCLES)));

    // R6: the pulse counter never exceeds its width
    p_pulse_bounded_r6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pulse <= CW'(PULSE_CYCLES));

    // R7: with the filter off no pulse can be started
    p_no_pulse_unfiltered_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!flt_i) && $past(st_q.pulse == '0)) |-> (st_q.pulse == '0));
endmodule

// File: rtl/gpio_irq_front.sv
module gpio_irq_front
    import gpio_irq_pkg::*;
#(
    parameter int NUM_LINES    = 8,
    parameter int PERIOD_W     = 8,
    parameter int PERIOD_RESET = 255,
    parameter int PULSE_CYCLES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr_en,
    input  logic [7:0]           reg_addr,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    input  logic [NUM_LINES-1:0] irq_in,
    output logic [NUM_LINES-1:0] irq_out
);
    logic [NUM_LINES-1:0] en_w, mode_w, flt_w;
    logic [PERIOD_W-1:0]  period_w;

    gpio_irq_regs #(
        .NUM_LINES   (NUM_LINES),
        .PERIOD_W    (PERIOD_W),
        .PERIOD_RESET(PERIOD_RESET)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr_en),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .rdata   (reg_rdata),
        .en_o    (en_w),
        .mode_o  (mode_w),
        .flt_o   (flt_w),
        .period_o(period_w)
    );

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_lane
        gpio_irq_lane #(
            .PERIOD_W    (PERIOD_W),
            .PULSE_CYCLES(PULSE_CYCLES)
        ) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .raw_i   (irq_in[i]),
            .period_i(period_w),
            .en_i    (en_w[i]),
            .mode_i  (mode_w[i]),
            .flt_i   (flt_w[i]),
            .out_o   (irq_out[i])
        );
    end

    // R2: unused upper bits of the line registers always read zero
    if (NUM_LINES < MAX_LINES) begin : g_hi_check
        p_high_bits_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_addr == OFS_ENABLE || reg_addr == OFS_MODE || reg_addr == OFS_FILTER)
                |-> (reg_rdata[31:NUM_LINES] == '0));
    end
endmodule

// File: tb/sim_gpio_irq_front.sv
module sim_gpio_irq_front;
    localparam int N = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [N-1:0] irq_in = '0;
    logic [N-1:0] irq_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    gpio_irq_front #(.NUM_LINES(N)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_in(irq_in), .irq_out(irq_out)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n  = 1'b0;
        irq_in = '0;
        step(2);
        rst_n = 1'b1;
        step(1);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr_en = 1'b1;
        step(1);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        do_reset();
        rd(8'h90, v); chk("R1 enable reset", v, 32'h0);
        rd(8'h94, v); chk("R1 mode reset", v, 32'h0);
        rd(8'h98, v); chk("R1 filter reset", v, 32'h0);
        rd(8'h9C, v); chk("R1 period reset", v, 32'h0000_00FF);
        chk("R1 outputs reset", 32'(irq_out), 32'h0);
    endtask

    task automatic t_regs();
        logic [31:0] v;
        do_reset();
        wr(8'h90, 32'hFFFF_FFFF);
        rd(8'h90, v); chk("R2 enable upper bits", v, 32'h0000_00FF);
        wr(8'h94, 32'h0000_005A);
        rd(8'h94, v); chk("R2 mode readback", v, 32'h0000_005A);
        wr(8'h98, 32'h0000_00C3);
        rd(8'h98, v); chk("R2 filter readback", v, 32'h0000_00C3);
        wr(8'h9C, 32'h1234_5607);
        rd(8'h9C, v); chk("R2 period readback", v, 32'h0000_0007);
        wr(8'h00, 32'h0000_0000);
        wr(8'h91, 32'h0000_0000);
        rd(8'h90, v); chk("R2 unmapped write ignored", v, 32'h0000_00FF);
        rd(8'h00, v); chk("R2 unmapped read zero", v, 32'h0);
    endtask

    task automatic t_disabled();
        do_reset();
        irq_in = 8'hFF;
        step(4);
        chk("R3 disabled pass-through idle 0", 32'(irq_out), 32'h0);
        wr(8'h98, 32'hFF);
        wr(8'h94, 32'hFF);
        wr(8'h9C, 32'h1);
        irq_in = 8'h00;
        step(1); chk("R3 disabled both-edge idle 1 (a)", 32'(irq_out), 32'hFF);
        step(1); chk("R3 disabled both-edge idle 1 (b)", 32'(irq_out), 32'hFF);
        step(1); chk("R3 disabled both-edge idle 1 (c)", 32'(irq_out), 32'hFF);
    endtask

    task automatic t_pass();
        do_reset();
        wr(8'h90, 32'hFF);
        irq_in = 8'hA5;
        step(1); chk("R4 not yet after one edge", 32'(irq_out), 32'h00);
        step(1); chk("R4 pattern A5 after two edges", 32'(irq_out), 32'hA5);
        irq_in = 8'h3C;
        step(1); chk("R4 holds old value one edge", 32'(irq_out), 32'hA5);
        step(1); chk("R4 pattern 3C after two edges", 32'(irq_out), 32'h3C);
    endtask

    task automatic t_filter();
        do_reset();
        wr(8'h90, 32'h01);
        wr(8'h98, 32'h01);
        wr(8'h9C, 32'h04);
        irq_in[0] = 1'b1;
        step(3);
        irq_in[0] = 1'b0;
        step(6);
        chk("R5 short glitch discarded", 32'(irq_out[0]), 32'h0);
        irq_in[0] = 1'b1;
        step(4); chk("R5 not accepted one edge early", 32'(irq_out[0]), 32'h0);
        step(1); chk("R5 accepted at 1+P edges", 32'(irq_out[0]), 32'h1);
        wr(8'h9C, 32'h00);
        irq_in[0] = 1'b0;
        step(1); chk("R5 period 0 not yet", 32'(irq_out[0]), 32'h1);
        step(1); chk("R5 period 0 acts as 1", 32'(irq_out[0]), 32'h0);
    endtask

    task automatic t_edge();
        do_reset();
        wr(8'h98, 32'h02);
        wr(8'h94, 32'h02);
        wr(8'h9C, 32'h02);
        wr(8'h90, 32'h02);
        chk("R6 idle high", 32'(irq_out[1]), 32'h1);
        irq_in[1] = 1'b1;
        step(2); chk("R6 rise: high before accept", 32'(irq_out[1]), 32'h1);
        step(1); chk("R6 rise: low cycle 1", 32'(irq_out[1]), 32'h0);
        step(1); chk("R6 rise: low cycle 2", 32'(irq_out[1]), 32'h0);
        step(1); chk("R6 rise: back high", 32'(irq_out[1]), 32'h1);
        step(2);
        irq_in[1] = 1'b0;
        step(2); chk("R6 fall: high before accept", 32'(irq_out[1]), 32'h1);
        step(1); chk("R6 fall: low cycle 1", 32'(irq_out[1]), 32'h0);
        step(1); chk("R6 fall: low cycle 2", 32'(irq_out[1]), 32'h0);
        step(1); chk("R6 fall: back high", 32'(irq_out[1]), 32'h1);
    endtask

    task automatic t_edge_nofilter();
        int lows;
        do_reset();
        wr(8'h94, 32'h04);
        wr(8'h90, 32'h04);
        lows = 0;
        for (int k = 0; k < 12; k++) begin
            if (k % 3 == 0) irq_in[2] = ~irq_in[2];
            step(1);
            if (irq_out[2] == 1'b0) lows++;
        end
        chk("R7 no pulse with filter off", 32'(lows), 32'h0);
    endtask

    initial begin
        int cyc;
        cyc = 0;
        while (!done && cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_regs();
        t_disabled();
        t_pass();
        t_filter();
        t_edge();
        t_edge_nofilter();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule